// File: doc/BRIEF.md
# Modem Status Delta Tracker

This block keeps the modem status register of a serial port. It watches four incoming handshake lines (clear-to-send, data-set-ready, ring and carrier detect), passes them through a synchronizer, and records in sticky change flags which lines have moved since software last read the register. A modem-status interrupt request is raised while any change flag is set. A read strobe returns the status byte and, outside loopback, clears the change flags.

The block also holds the five-bit modem control register. When its loopback bit is set, the status byte no longer reflects the pins. It is rebuilt from the modem control outputs instead, so software can exercise its handshake code without a cable. In loopback mode a read does not disturb the change flags gathered from the pins.

Top module: `modem_status_tracker`

## Requirements
- R1: After reset the status byte reads 0xB0 (carrier, data-set-ready and clear-to-send set, ring clear, no change flags) and `irq` is low.
- R2: The status byte holds the line levels in bits 7..4: bit 7 carrier, bit 6 ring, bit 5 data-set-ready, bit 4 clear-to-send. A change of the carrier, data-set-ready or clear-to-send line sets its change flag (bit 3, bit 1 and bit 0 respectively). The flag stays set while no clearing read occurs, even if the line returns to its old level.
- R3: The ring change flag (bit 2) is set only when the ring line goes from 1 to 0. A rise of the ring line leaves bit 2 clear.
- R4: A read strobe outside loopback returns the current byte and clears bits 3..0 on the following clock edge, unless a line changes in that same cycle. Bits 7..4 are not affected.
- R5: With loopback enabled (control bit 4), the status byte reads control bit 3 in bit 7, control bit 2 in bit 6, control bit 0 in bit 5, control bit 1 in bit 4, and zero in bits 3..0.
- R6: The modem control register is 5 bits wide: bit 0 and bit 1 are the two handshake outputs, bits 2 and 3 are the two general outputs, and bit 4 is loopback. It resets to 0x08 and takes `mcr_wdata` on a write strobe.
- R7: A read strobe in loopback mode leaves the change flags collected from the pins untouched. They are visible again once loopback is left.
- R8: `irq` is high exactly when at least one of the four change flags is set, independent of loopback.
- R9: A pin change becomes visible in the status byte and in `irq` after the third rising clock edge following it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| ri_i | input | 1 | Ring line, asynchronous |
| dcd_i | input | 1 | Carrier-detect line, asynchronous |
| mcr_we | input | 1 | Modem control register write strobe |
| mcr_wdata | input | 5 | Modem control write data |
| mcr_q | output | 5 | Modem control register contents |
| rd_stb | input | 1 | Status register read strobe |
| status_q | output | 8 | Status byte |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The single-line falls and rises of clear-to-send separate a correct change flag from one that is missing or mirrors the level. The rise and the later fall of the ring line show whether the trailing-edge rule is applied or whether a plain change is taken. A simultaneous fall of carrier and data-set-ready, and a pulse that returns to its old level, check that the flags land in the right bit positions and that they stay set. A sweep of single control bits in loopback, with a pending pin flag held across it, exposes swapped output mapping and a read that clears the flags when it should not.

// File: rtl/modem_status_tracker.sv
module modem_status_tracker #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  input  logic       mcr_we,
  input  logic [4:0] mcr_wdata,
  output logic [4:0] mcr_q,
  input  logic       rd_stb,
  output logic [7:0] status_q,
  output logic       irq
);
  localparam logic [3:0] LINES_RST = 4'b1011;
  localparam logic [4:0] MCR_RST   = 5'b01000;
  localparam int         RI_BIT    = 2;
  localparam int         LOOP_BIT  = 4;

  logic [3:0] sync_q [SYNC_STAGES];
  logic [3:0] line_q;
  logic [3:0] delta_q;
  logic [4:0] mcr_r;

  wire [3:0] pins      = {dcd_i, ri_i, dsr_i, cts_i};
  wire [3:0] line_now  = sync_q[SYNC_STAGES-1];
  wire [3:0] flip      = line_now ^ line_q;
  wire       ri_trail  = line_q[RI_BIT] & ~line_now[RI_BIT];
  wire [3:0] delta_new = {flip[3], ri_trail, flip[1], flip[0]};
  wire       loop_en   = mcr_r[LOOP_BIT];
  wire       clr       = rd_stb & ~loop_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= LINES_RST;
    end else begin
      sync_q[0] <= pins;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= LINES_RST;
      delta_q <= '0;
    end else begin
      line_q  <= line_now;
      delta_q <= (clr ? 4'b0000 : delta_q) | delta_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mcr_r <= MCR_RST;
    else if (mcr_we) mcr_r <= mcr_wdata;
  end

  assign mcr_q    = mcr_r;
  assign status_q = loop_en ? {mcr_r[3], mcr_r[2], mcr_r[0], mcr_r[1], 4'b0000}
                            : {line_q, delta_q};
  assign irq      = |delta_q;
endmodule

module modem_status_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic       mcr_we,
  input logic [4:0] mcr_wdata,
  input logic [4:0] mcr_q,
  input logic [7:0] status_q,
  input logic       irq,
  input logic [3:0] line_now,
  input logic [3:0] line_q
);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && (!rd_stb || mcr_q[4])) |=> irq);

  assert_ri_rise_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mcr_q[4] && $past(!mcr_q[4]) && $rose(status_q[6])) |-> !$rose(status_q[2]));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !mcr_q[4] && line_now == line_q) |=> !irq);

  assert_loop_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_q[4] |-> status_q[3:0] == 4'b0000);

  assert_mcr_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_we |=> mcr_q == $past(mcr_wdata));

  assert_irq_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mcr_q[4] |-> irq == (|status_q[3:0]));
endmodule

bind modem_status_tracker modem_status_tracker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .mcr_we(mcr_we),
  .mcr_wdata(mcr_wdata), .mcr_q(mcr_q), .status_q(status_q), .irq(irq),
  .line_now(line_now), .line_q(line_q)
);

// File: tb/modem_status_tracker_tb_top.sv
module modem_status_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cts_i = 1'b1, dsr_i = 1'b1, ri_i = 1'b0, dcd_i = 1'b1;
  logic       mcr_we = 1'b0;
  logic [4:0] mcr_wdata = '0;
  logic [4:0] mcr_q;
  logic       rd_stb = 1'b0;
  logic [7:0] status_q;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  modem_status_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i),
    .dcd_i(dcd_i), .mcr_we(mcr_we), .mcr_wdata(mcr_wdata), .mcr_q(mcr_q),
    .rd_stb(rd_stb), .status_q(status_q), .irq(irq)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  task automatic read_exp(input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic write_mcr(input logic [4:0] v);
    @(negedge clk);
    mcr_we = 1'b1;
    mcr_wdata = v;
    @(negedge clk);
    mcr_we = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rd_stb) begin
        if (exp_q.size() == 0) begin
          check(status_q, 8'hxx, "unexpected read");
        end else begin
          check(status_q, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({7'd0, irq}, 8'h00, "R1 irq after reset");
    check({3'd0, mcr_q}, 8'h08, "R6 control reset");
    read_exp(8'hB0, "R1 status after reset");

    @(negedge clk);
    cts_i = 1'b0;
    @(posedge clk); @(posedge clk); #2;
    check({7'd0, irq}, 8'h00, "R9 not visible after two edges");
    @(posedge clk); #2;
    check({7'd0, irq}, 8'h01, "R9 visible after three edges");
    read_exp(8'hA1, "R2 cts fall flag");
    @(negedge clk);
    check({7'd0, irq}, 8'h00, "R4 irq cleared by read");
    read_exp(8'hA0, "R4 flags cleared");

    @(negedge clk);
    ri_i = 1'b1;
    settle();
    @(negedge clk);
    check({7'd0, irq}, 8'h00, "R3 ring rise raises nothing");
    read_exp(8'hE0, "R3 ring rise no flag");
    @(negedge clk);
    ri_i = 1'b0;
    settle();
    read_exp(8'hA4, "R3 ring trailing edge flag");
    @(negedge clk);
    check({7'd0, irq}, 8'h00, "R8 irq low with no flags");

    @(negedge clk);
    dcd_i = 1'b0;
    dsr_i = 1'b0;
    settle();
    read_exp(8'h0A, "R2 carrier and dsr together");

    @(negedge clk);
    cts_i = 1'b1;
    settle();
    @(negedge clk);
    cts_i = 1'b0;
    settle();
    read_exp(8'h01, "R2 flag sticky after return");

    @(negedge clk);
    cts_i = 1'b1;
    settle();
    write_mcr(5'h1F);
    check({3'd0, mcr_q}, 8'h1F, "R6 control write");
    read_exp(8'hF0, "R5 loopback all outputs");
    @(negedge clk);
    check({7'd0, irq}, 8'h01, "R7 irq kept in loopback");
    write_mcr(5'h11);
    read_exp(8'h20, "R5 bit0 to bit5");
    write_mcr(5'h12);
    read_exp(8'h10, "R5 bit1 to bit4");
    write_mcr(5'h14);
    read_exp(8'h40, "R5 bit2 to bit6");
    write_mcr(5'h18);
    read_exp(8'h80, "R5 bit3 to bit7");
    write_mcr(5'h08);
    check({3'd0, mcr_q}, 8'h08, "R6 loopback off");
    read_exp(8'h11, "R7 flag kept across loopback reads");
    read_exp(8'h10, "R4 cleared after normal read");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check(8'(exp_q.size()), 8'h00, "scoreboard drained");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule